// File: doc/BRIEF.md
# Bus write FIFO status timer

This block produces three status flags that mimic a bus write FIFO draining after the processor posts a word. It has no data path. It takes a write strobe and a free-running tick, and from these it times when each flag rises and falls. The host reads the flags from a small status word.

The three flags form a staggered pipeline. The accept flag (bit 5) comes up with the write. The transfer flag (bit 4) comes up once the accept stage has run. The done flag (bit 0) comes up after that. Each flag edge has its own deadline counter. A later write lengthens the time a flag stays high by one full stage delay for each write. It never moves the moment a flag first rises.

The block is used as a timing stand-in wherever software polls the FIFO state before it issues more bus writes. All delays are counted in ticks, and the tick input can pause the timing.

Top module: `fifo_stat_timer`

## Requirements
- R1: A synchronous reset drives the status word to 0 and cancels every pending deadline. After reset no flag rises until a write is accepted.
- R2: A write sampled at clock edge E sets bit 5 of the status word from edge E onward.
- R3: After a single write at edge E with a tick on every cycle, bit 5 falls at the 60th tick edge after E.
- R4: After a first write at edge E, bit 4 rises at the 60th tick edge after E and falls 160 ticks after that rise (the 220th tick).
- R5: After a first write at edge E, bit 0 rises at the 120th tick edge after E and falls 420 ticks after that rise (the 540th tick).
- R6: A write that arrives while a flag's fall deadline is still pending adds that flag's full delay (60, 160 or 420 ticks) to the time that remains.
- R7: A write that arrives while a rise deadline is pending leaves that rise time unchanged.
- R8: Deadlines advance only on cycles where tick is high. Cycles without a tick push every edge later by one cycle.
- R9: Every status bit other than 5, 4 and 0 always reads 0.
- R10: A write on the same edge that bit 5's fall deadline expires keeps bit 5 high and starts a fresh 60-tick fall deadline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timing tick; deadlines count down only when it is high |
| wr | input | 1 | Bus write strobe, one write per cycle it is high |
| status | output | STAT_W | Registered status word: accept flag at bit 5, transfer flag at bit 4, done flag at bit 0 |

## Verification
Each flag edge is due a fixed number of tick edges after the write edge that armed it. Bit 5 comes up on the write edge itself. The other edges fall 60, 120, 220 or 540 ticks later, with the increments from extending writes added on and any tick-free cycles counted in. The driver computes the absolute cycle of each expected status word from these numbers before it drives the write. It then queues checks one cycle before and exactly on each edge. The monitor samples the registered status on the falling clock edge and compares it only in the cycle the queue names, so an edge that arrives one cycle early or late fails the check.

// File: rtl/fst_pkg.sv
package fst_pkg;

  // Flag edge events produced by the deadline counters in one cycle.
  typedef struct packed {
    logic acc_off;
    logic xfer_on;
    logic xfer_off;
    logic done_on;
    logic done_off;
  } fst_evt_t;

endpackage

// File: rtl/fst_deadline.sv
// One deadline: a down-counter with a separate valid bit. It fires on the
// tick that takes it from 1 to expiry. A write loads an idle deadline with
// base. For an extending deadline (EXTEND=1) a write on a pending deadline
// adds STEP, saturating; otherwise the pending value is kept.
module fst_deadline #(
  parameter int CNT_W  = 16,
  parameter bit EXTEND = 1'b0,
  parameter int STEP   = 60
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr,
  input  logic [CNT_W-1:0] base,
  output logic             fire,
  output logic [CNT_W-1:0] cnt_nxt
);

  localparam logic [CNT_W:0] STEP_EXT = (CNT_W+1)'(STEP);

  logic             vld_q;
  logic [CNT_W-1:0] cnt_q;
  logic             aged_vld;
  logic [CNT_W-1:0] aged_cnt;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] ext_cnt;
  logic             vld_nxt;

  always_comb begin
    fire     = vld_q && tick && (cnt_q == CNT_W'(1));
    aged_vld = vld_q && !fire;
    aged_cnt = (vld_q && tick && !fire) ? cnt_q - CNT_W'(1) : cnt_q;
    sum      = {1'b0, aged_cnt} + STEP_EXT;
    if (EXTEND)
      ext_cnt = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    else
      ext_cnt = aged_cnt;
    vld_nxt = aged_vld;
    cnt_nxt = aged_cnt;
    if (wr) begin
      vld_nxt = 1'b1;
      cnt_nxt = aged_vld ? ext_cnt : base;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      vld_q <= vld_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !vld_q); // R1
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    vld_q && tick && cnt_q > CNT_W'(1) && !wr |=> vld_q && cnt_q == $past(cnt_q) - CNT_W'(1)); // R8
  AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    vld_q && !tick && !wr |=> vld_q && $stable(cnt_q)); // R8

  generate
    if (EXTEND) begin : g_ext_chk
      AST_EXTEND_GROWS: assert property (@(posedge clk) disable iff (rst)
        vld_q && !fire && wr |=> vld_q && cnt_q >= $past(cnt_q)); // R6
    end else begin : g_rise_chk
      AST_RISE_FIXED: assert property (@(posedge clk) disable iff (rst)
        vld_q && tick && cnt_q > CNT_W'(1) && wr |=> vld_q && cnt_q == $past(cnt_q) - CNT_W'(1)); // R7
    end
  endgenerate

endmodule

// File: rtl/fst_flag_reg.sv
// Registered status word. Rise events are applied before fall events; a
// write sets the accept flag after its fall event is applied.
module fst_flag_reg
  import fst_pkg::*;
#(
  parameter int STAT_W   = 8,
  parameter int ACC_BIT  = 5,
  parameter int XFER_BIT = 4,
  parameter int DONE_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  fst_evt_t          evt,
  output logic [STAT_W-1:0] status_q
);

  logic [STAT_W-1:0] status_n;
  logic acc_n, xfer_n, done_n;

  always_comb begin
    acc_n = status_q[ACC_BIT];
    if (evt.acc_off) acc_n = 1'b0;
    if (wr)          acc_n = 1'b1;
    xfer_n = status_q[XFER_BIT];
    if (evt.xfer_on)  xfer_n = 1'b1;
    if (evt.xfer_off) xfer_n = 1'b0;
    done_n = status_q[DONE_BIT];
    if (evt.done_on)  done_n = 1'b1;
    if (evt.done_off) done_n = 1'b0;
    status_n           = '0;
    status_n[ACC_BIT]  = acc_n;
    status_n[XFER_BIT] = xfer_n;
    status_n[DONE_BIT] = done_n;
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_n;
  end

  AST_WR_SETS_ACC: assert property (@(posedge clk) disable iff (rst)
    wr |=> status_q[ACC_BIT]); // R2
  AST_ACC_FALL_SRC: assert property (@(posedge clk) disable iff (rst)
    $fell(status_q[ACC_BIT]) |-> $past(evt.acc_off) && !$past(wr)); // R10
  AST_XFER_RISE_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[XFER_BIT]) |-> $past(evt.xfer_on)); // R4
  AST_DONE_RISE_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[DONE_BIT]) |-> $past(evt.done_on)); // R5

endmodule

// File: rtl/fifo_stat_timer.sv
module fifo_stat_timer
  import fst_pkg::*;
#(
  parameter int STAT_W        = 8,
  parameter int ACC_BIT       = 5,
  parameter int XFER_BIT      = 4,
  parameter int DONE_BIT      = 0,
  parameter int CNT_W         = 16,
  parameter int ACC_TICKS     = 60,
  parameter int XFER_ON_TICKS = 60,
  parameter int XFER_TICKS    = 160,
  parameter int DONE_ON_TICKS = 120,
  parameter int DONE_TICKS    = 420
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr,
  output logic [STAT_W-1:0] status
);

  localparam logic [CNT_W-1:0] ACC_BASE  = CNT_W'(ACC_TICKS);
  localparam logic [CNT_W-1:0] XON_BASE  = CNT_W'(XFER_ON_TICKS);
  localparam logic [CNT_W-1:0] DON_BASE  = CNT_W'(DONE_ON_TICKS);
  localparam logic [CNT_W:0]   XOFF_ADD  = (CNT_W+1)'(XFER_TICKS);
  localparam logic [CNT_W:0]   DOFF_ADD  = (CNT_W+1)'(DONE_TICKS);

  fst_evt_t         evt;
  logic [CNT_W-1:0] acc_off_nxt, xfer_on_nxt, xfer_off_nxt, done_on_nxt, done_off_nxt;
  logic [CNT_W-1:0] xfer_off_base, done_off_base;
  logic [CNT_W:0]   xoff_sum, doff_sum;

  // A fall deadline armed from idle is placed relative to its rise deadline.
  always_comb begin
    xoff_sum      = {1'b0, xfer_on_nxt} + XOFF_ADD;
    doff_sum      = {1'b0, done_on_nxt} + DOFF_ADD;
    xfer_off_base = xoff_sum[CNT_W] ? {CNT_W{1'b1}} : xoff_sum[CNT_W-1:0];
    done_off_base = doff_sum[CNT_W] ? {CNT_W{1'b1}} : doff_sum[CNT_W-1:0];
  end

  fst_deadline #(.CNT_W(CNT_W), .EXTEND(1'b1), .STEP(ACC_TICKS)) u_acc_off (
    .clk(clk), .rst(rst), .tick(tick), .wr(wr), .base(ACC_BASE),
    .fire(evt.acc_off), .cnt_nxt(acc_off_nxt));

  fst_deadline #(.CNT_W(CNT_W), .EXTEND(1'b0), .STEP(XFER_ON_TICKS)) u_xfer_on (
    .clk(clk), .rst(rst), .tick(tick), .wr(wr), .base(XON_BASE),
    .fire(evt.xfer_on), .cnt_nxt(xfer_on_nxt));

  fst_deadline #(.CNT_W(CNT_W), .EXTEND(1'b1), .STEP(XFER_TICKS)) u_xfer_off (
    .clk(clk), .rst(rst), .tick(tick), .wr(wr), .base(xfer_off_base),
    .fire(evt.xfer_off), .cnt_nxt(xfer_off_nxt));

  fst_deadline #(.CNT_W(CNT_W), .EXTEND(1'b0), .STEP(DONE_ON_TICKS)) u_done_on (
    .clk(clk), .rst(rst), .tick(tick), .wr(wr), .base(DON_BASE),
    .fire(evt.done_on), .cnt_nxt(done_on_nxt));

  fst_deadline #(.CNT_W(CNT_W), .EXTEND(1'b1), .STEP(DONE_TICKS)) u_done_off (
    .clk(clk), .rst(rst), .tick(tick), .wr(wr), .base(done_off_base),
    .fire(evt.done_off), .cnt_nxt(done_off_nxt));

  fst_flag_reg #(
    .STAT_W(STAT_W), .ACC_BIT(ACC_BIT), .XFER_BIT(XFER_BIT), .DONE_BIT(DONE_BIT)
  ) u_flags (
    .clk(clk), .rst(rst), .wr(wr), .evt(evt), .status_q(status));

  AST_XFER_ORDER: assert property (@(posedge clk) disable iff (rst)
    wr |-> xfer_off_nxt > xfer_on_nxt); // R4
  AST_DONE_ORDER: assert property (@(posedge clk) disable iff (rst)
    wr |-> done_off_nxt > done_on_nxt); // R5
  AST_ACC_ARMED: assert property (@(posedge clk) disable iff (rst)
    wr |-> acc_off_nxt >= ACC_BASE); // R6

endmodule

// File: tb/fifo_stat_timer_tb_top.sv
module fifo_stat_timer_tb_top;

  typedef struct {
    int          cyc;
    logic [7:0]  val;
    string       req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic       wr = 1'b0;
  logic [7:0] status;

  int   cyc = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t sb[$];
  exp_t item;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fifo_stat_timer dut_i (
    .clk(clk), .rst(rst), .tick(tick), .wr(wr), .status(status));

  // Monitor: compares the status word in exactly the cycle each item names.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      item = sb.pop_front();
      n_checks++;
      if (item.cyc < cyc)
        begin n_fail++; $display("FAIL %s: check for cycle %0d missed, actual %02h expected %02h", item.req, item.cyc, status, item.val); end
      else if (status !== item.val)
        begin n_fail++; $display("FAIL %s: cycle %0d actual %02h expected %02h", item.req, cyc, status, item.val); end
    end
  end

  task automatic expect_at(int c, logic [7:0] v, string r);
    exp_t e;
    e.cyc = c; e.val = v; e.req = r;
    sb.push_back(e);
  endtask

  task automatic pulse_wr();
    wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: idle after reset, nothing rises without a write
    expect_at(cyc + 1, 8'h00, "R1");
    expect_at(cyc + 40, 8'h00, "R1");
    drain();

    // Single write: full staggered sequence (R2 R3 R4 R5 R9)
    w = cyc + 1;
    expect_at(w,       8'h20, "R2");
    expect_at(w + 59,  8'h20, "R3");
    expect_at(w + 60,  8'h10, "R3");
    expect_at(w + 119, 8'h10, "R4");
    expect_at(w + 120, 8'h11, "R5");
    expect_at(w + 219, 8'h11, "R4");
    expect_at(w + 220, 8'h01, "R4");
    expect_at(w + 300, 8'h01, "R9");
    expect_at(w + 539, 8'h01, "R5");
    expect_at(w + 540, 8'h00, "R5");
    pulse_wr();
    drain();

    // Second write 10 cycles later: falls extend, rises stay (R6 R7)
    w = cyc + 1;
    expect_at(w + 11,  8'h20, "R2");
    expect_at(w + 59,  8'h20, "R6");
    expect_at(w + 60,  8'h30, "R7");
    expect_at(w + 119, 8'h30, "R6");
    expect_at(w + 120, 8'h11, "R7");
    expect_at(w + 379, 8'h11, "R6");
    expect_at(w + 380, 8'h01, "R6");
    expect_at(w + 959, 8'h01, "R6");
    expect_at(w + 960, 8'h00, "R6");
    pulse_wr();
    repeat (9) @(negedge clk);
    pulse_wr();
    drain();

    // Second write on the edge bit 5 would fall (R10)
    w = cyc + 1;
    expect_at(w + 59,  8'h20, "R10");
    expect_at(w + 60,  8'h30, "R10");
    expect_at(w + 119, 8'h30, "R10");
    expect_at(w + 120, 8'h11, "R10");
    expect_at(w + 379, 8'h11, "R6");
    expect_at(w + 380, 8'h01, "R6");
    expect_at(w + 959, 8'h01, "R6");
    expect_at(w + 960, 8'h00, "R6");
    pulse_wr();
    repeat (59) @(negedge clk);
    pulse_wr();
    drain();

    // Tick withheld for 20 cycles after the write (R8)
    w = cyc + 1;
    expect_at(w + 20,  8'h20, "R8");
    expect_at(w + 79,  8'h20, "R8");
    expect_at(w + 80,  8'h10, "R8");
    expect_at(w + 139, 8'h10, "R8");
    expect_at(w + 140, 8'h11, "R8");
    expect_at(w + 240, 8'h01, "R8");
    expect_at(w + 559, 8'h01, "R8");
    expect_at(w + 560, 8'h00, "R8");
    pulse_wr();
    tick = 1'b0;
    repeat (20) @(negedge clk);
    tick = 1'b1;
    drain();

    // Reset while flags are active cancels pending deadlines (R1)
    w = cyc + 1;
    expect_at(w + 65,  8'h10, "R4");
    expect_at(w + 71,  8'h00, "R1");
    expect_at(w + 73,  8'h00, "R1");
    expect_at(w + 130, 8'h00, "R1");
    expect_at(w + 600, 8'h00, "R1");
    pulse_wr();
    repeat (70) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    drain();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule